// File: doc/BRIEF.md
# Serial Flash Write-Protection Checker

This block sits between the command decoder of a serial flash device and its program/erase engine. It decides whether a pending program or erase operation may go ahead. The protection settings are taken as plain inputs: a granularity select, an origin select, a three-bit protect code and an invert bit. The block turns them into one contiguous protected address window. It then compares that window with the byte range that the requested operation would touch. The array is 2 MB, built from 32 blocks of 64 kB, and each block holds 4 kB sectors.

A request is presented with a one-cycle strobe, an operation kind and a start address. Exactly one clock later the block raises a one-cycle `done` pulse. At the same edge it updates a `reject` flag and the inclusive bounds of the protected window. These stay valid until the next strobe. When `reject` is high the operation is dropped in full, never in part.

Top module: `wp_guard`

## Requirements
- R1: After reset, `done`, `reject` and `prot_any` are 0, and `prot_lo` and `prot_hi` are 0.
- R2: With `cfg_sec_sel`=0, protect codes 1 to 5 protect a window of 64 kB, 128 kB, 256 kB, 512 kB or 1 MB. The window ends at the top address 0x1FFFFF when `cfg_from_bottom`=0 and starts at address 0 when `cfg_from_bottom`=1.
- R3: Protect code 0 protects nothing. Codes 6 and 7 protect the whole array (0x000000 to 0x1FFFFF) for any value of `cfg_sec_sel` and `cfg_from_bottom`.
- R4: With `cfg_sec_sel`=1, protect codes 1, 2 and 3 protect 4 kB, 8 kB and 16 kB, and codes 4 and 5 both protect 32 kB. The window is placed at the edge that `cfg_from_bottom` selects.
- R5: With `cfg_invert`=1 the protected window is the complement of the window that R2 to R4 give. No protection becomes the whole array, the whole array becomes no protection, and an edge window of size S becomes the opposite contiguous window of 2 MB minus S.
- R6: `req_kind` encodes 0 = 256-byte page, 1 = 4 kB sector, 2 = 64 kB block, 3 = whole chip. The operation touches the aligned unit of that size that contains `req_addr`. A whole-chip operation touches every address.
- R7: `reject` is 1 exactly when the touched range shares at least one byte with the protected window. An operation that ends one byte below the window, or starts one byte above it, is accepted.
- R8: A whole-chip operation is rejected whenever any byte of the array is protected, and is accepted only when `prot_any`=0.
- R9: `done` pulses high for exactly one cycle, one clock after a cycle with `req_valid`=1. `reject`, `prot_any`, `prot_lo` and `prot_hi` update only at that edge and hold while no request is strobed, even if the settings change.
- R10: When `prot_any`=0, `prot_lo` and `prot_hi` both read 0. When `prot_any`=1 they give the inclusive first and last protected byte addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sec_sel | input | 1 | 1 = protect codes count 4 kB sectors, 0 = 64 kB blocks |
| cfg_from_bottom | input | 1 | 1 = window grows up from address 0, 0 = down from the top |
| cfg_bp | input | 3 | Protect code |
| cfg_invert | input | 1 | 1 = swap protected and unprotected areas |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Operation kind (R6 encoding) |
| req_addr | input | 21 | Operation start address |
| done | output | 1 | One-cycle pulse, one clock after the strobe |
| reject | output | 1 | Last request overlaps the protected window |
| prot_any | output | 1 | Protected window is non-empty |
| prot_lo | output | 21 | First protected address |
| prot_hi | output | 21 | Last protected address |

## Verification
The bench builds the block with its default parameters: a 21-bit address, 64 kB blocks, 4 kB sectors and 256-byte pages. Every one of the 64 settings combinations then maps onto the exact 2 MB geometry the requirements name. With these values a single page probe can sit one byte inside or one byte outside each window edge. The sector-mode windows of 4 kB to 32 kB and their complements are reached in full. The bench also runs whole-chip and block-sized operations across the window edges.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        OP_PAGE   = 2'd0,
        OP_SECTOR = 2'd1,
        OP_BLOCK  = 2'd2,
        OP_CHIP   = 2'd3
    } op_kind_e;
endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
    parameter int ADDR_W     = 21,
    parameter int BLOCK_W    = 16,
    parameter int SECTOR_W   = 12,
    parameter int SECT_MAXSH = 3
) (
    input  logic              sec_sel,
    input  logic              from_bottom,
    input  logic [2:0]        bp,
    input  logic              invert,
    output logic              prot_any,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [5:0] BLK_SH  = 6'(BLOCK_W);
    localparam logic [5:0] SECT_SH = 6'(SECTOR_W);
    localparam logic [2:0] SECT_CAP = 3'(SECT_MAXSH);

    logic              base_none;
    logic              base_full;
    logic [2:0]        step;
    logic [5:0]        shamt;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_lo;
    logic [ADDR_W-1:0] base_hi;

    always_comb begin
        base_none = (bp == 3'd0);
        base_full = bp[2] & bp[1];
        step      = bp - 3'd1;
        if (sec_sel && (step > SECT_CAP)) begin
            step = SECT_CAP;
        end
        shamt = (sec_sel ? SECT_SH : BLK_SH) + {3'b000, step};
        mask  = ADDR_W'((ADDR_W+1)'(1) << shamt) - ADDR_W'(1);

        if (from_bottom) begin
            base_lo = '0;
            base_hi = mask;
        end else begin
            base_lo = TOP_ADDR - mask;
            base_hi = TOP_ADDR;
        end

        prot_any = 1'b0;
        prot_lo  = '0;
        prot_hi  = '0;
        if (!invert) begin
            if (base_full) begin
                prot_any = 1'b1;
                prot_hi  = TOP_ADDR;
            end else if (!base_none) begin
                prot_any = 1'b1;
                prot_lo  = base_lo;
                prot_hi  = base_hi;
            end
        end else begin
            if (base_none) begin
                prot_any = 1'b1;
                prot_hi  = TOP_ADDR;
            end else if (!base_full) begin
                prot_any = 1'b1;
                if (from_bottom) begin
                    prot_lo = base_hi + ADDR_W'(1);
                    prot_hi = TOP_ADDR;
                end else begin
                    prot_lo = '0;
                    prot_hi = base_lo - ADDR_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/wp_op_range.sv
module wp_op_range
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int PAGE_W   = 8,
    parameter int SECTOR_W = 12,
    parameter int BLOCK_W  = 16
) (
    input  op_kind_e          kind,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] op_lo,
    output logic [ADDR_W-1:0] op_hi
);
    localparam int NUM_KINDS = 4;
    logic [ADDR_W-1:0] unit_mask [NUM_KINDS];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_mask
        localparam int UW = (k == 0) ? PAGE_W :
                            (k == 1) ? SECTOR_W :
                            (k == 2) ? BLOCK_W : ADDR_W;
        if (UW >= ADDR_W) begin : g_all
            assign unit_mask[k] = {ADDR_W{1'b1}};
        end else begin : g_part
            assign unit_mask[k] = {{(ADDR_W-UW){1'b0}}, {UW{1'b1}}};
        end
    end

    always_comb begin
        op_lo = addr & ~unit_mask[kind];
        op_hi = addr |  unit_mask[kind];
    end
endmodule

// File: rtl/wp_overlap.sv
module wp_overlap #(
    parameter int ADDR_W = 21
) (
    input  logic              win_any,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic [ADDR_W-1:0] op_lo,
    input  logic [ADDR_W-1:0] op_hi,
    output logic              hit
);
    always_comb begin
        hit = win_any && (op_lo <= win_hi) && (op_hi >= win_lo);
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int BLOCK_W    = 16,
    parameter int SECTOR_W   = 12,
    parameter int PAGE_W     = 8,
    parameter int SECT_MAXSH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sec_sel,
    input  logic              cfg_from_bottom,
    input  logic [2:0]        cfg_bp,
    input  logic              cfg_invert,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic              reject,
    output logic              prot_any,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic              done;
        logic              reject;
        logic              any;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } guard_state_t;

    guard_state_t      st_d, st_q;
    logic              win_any;
    logic [ADDR_W-1:0] win_lo, win_hi, op_lo, op_hi;
    logic              hit;
    op_kind_e          kind;

    assign kind = op_kind_e'(req_kind);

    wp_region_decode #(
        .ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W),
        .SECTOR_W(SECTOR_W), .SECT_MAXSH(SECT_MAXSH)
    ) u_region (
        .sec_sel(cfg_sec_sel), .from_bottom(cfg_from_bottom),
        .bp(cfg_bp), .invert(cfg_invert),
        .prot_any(win_any), .prot_lo(win_lo), .prot_hi(win_hi)
    );

    wp_op_range #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
        .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)
    ) u_range (
        .kind(kind), .addr(req_addr), .op_lo(op_lo), .op_hi(op_hi)
    );

    wp_overlap #(.ADDR_W(ADDR_W)) u_overlap (
        .win_any(win_any), .win_lo(win_lo), .win_hi(win_hi),
        .op_lo(op_lo), .op_hi(op_hi), .hit(hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (req_valid) begin
            st_d.done   = 1'b1;
            st_d.reject = hit;
            st_d.any    = win_any;
            st_d.lo     = win_lo;
            st_d.hi     = win_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign reject   = st_q.reject;
    assign prot_any = st_q.any;
    assign prot_lo  = st_q.lo;
    assign prot_hi  = st_q.hi;

    assert_bounds_ordered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_any |-> (prot_lo <= prot_hi));

    assert_edge_anchored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_any |-> ((prot_lo == '0) || (prot_hi == TOP_ADDR)));

    assert_no_reject_unprotected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !prot_any) |-> !reject);

    assert_chip_rejects_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (kind == OP_CHIP)) |=> (reject == prot_any));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(reject) && $stable(prot_lo) && $stable(prot_hi) && !done));
endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;
    localparam logic [AW-1:0] TOPA = 21'h1FFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_sel = 0, from_bottom = 0, invert = 0;
    logic [2:0] bp = 0;
    logic req_valid = 0;
    logic [1:0] req_kind = 0;
    logic [AW-1:0] req_addr = 0;
    logic o_done, o_reject, o_any;
    logic [AW-1:0] o_lo, o_hi;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sec_sel(sec_sel), .cfg_from_bottom(from_bottom),
        .cfg_bp(bp), .cfg_invert(invert),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .done(o_done), .reject(o_reject), .prot_any(o_any),
        .prot_lo(o_lo), .prot_hi(o_hi)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference window: returns {any, lo, hi}
    function automatic logic [2*AW:0] ref_window(input logic s, input logic b,
                                                 input logic [2:0] code, input logic inv);
        int unsigned sz;
        logic any; logic [AW-1:0] lo, hi;
        if (s) begin
            case (code)
                3'd1: sz = 4096;
                3'd2: sz = 8192;
                3'd3: sz = 16384;
                default: sz = 32768;
            endcase
        end else begin
            case (code)
                3'd1: sz = 65536;
                3'd2: sz = 131072;
                3'd3: sz = 262144;
                3'd4: sz = 524288;
                default: sz = 1048576;
            endcase
        end
        if (code == 3'd0) sz = 0;
        if (code >= 3'd6) sz = 2097152;
        if (inv) sz = 2097152 - sz;
        any = (sz != 0);
        lo = 0; hi = 0;
        if (any) begin
            // inverted window sits at the opposite edge
            if (b ^ inv) begin lo = 0; hi = AW'(sz - 1); end
            else begin lo = AW'(2097152 - sz); hi = TOPA; end
            if (sz == 2097152) begin lo = 0; hi = TOPA; end
        end
        return {any, lo, hi};
    endfunction

    task automatic set_cfg(input logic s, input logic b, input logic [2:0] c, input logic i);
        sec_sel = s; from_bottom = b; bp = c; invert = i;
    endtask

    task automatic issue(input logic [1:0] k, input logic [AW-1:0] a);
        @(negedge clk);
        req_kind = k; req_addr = a; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic test_reset;
        check("R1", "done", 32'(o_done), 0);
        check("R1", "reject", 32'(o_reject), 0);
        check("R1", "any", 32'(o_any), 0);
        check("R1", "lo", 32'(o_lo), 0);
        check("R1", "hi", 32'(o_hi), 0);
    endtask

    task automatic test_all_combos;
        for (int c = 0; c < 64; c++) begin
            logic [2*AW:0] r;
            string tag;
            set_cfg(c[5], c[4], c[3:1], c[0]);
            r = ref_window(c[5], c[4], c[3:1], c[0]);
            if (c[0]) tag = "R5";
            else if (c[3:1] == 0 || c[3:1] >= 6) tag = "R3";
            else if (c[5]) tag = "R4";
            else tag = "R2";
            issue(2'd0, 21'h0);
            check(tag, $sformatf("any cfg=%0d", c), 32'(o_any), 32'(r[2*AW]));
            check(tag, $sformatf("lo cfg=%0d", c), 32'(o_lo), 32'(r[2*AW-1:AW]));
            check(tag, $sformatf("hi cfg=%0d", c), 32'(o_hi), 32'(r[AW-1:0]));
            if (!r[2*AW]) check("R10", "empty bounds", 32'({o_lo, o_hi}), 0);
        end
    endtask

    task automatic test_boundaries;
        for (int c = 0; c < 64; c++) begin
            logic [2*AW:0] r;
            logic [AW-1:0] lo, hi;
            r = ref_window(c[5], c[4], c[3:1], c[0]);
            if (r[2*AW]) begin
                lo = r[2*AW-1:AW]; hi = r[AW-1:0];
                set_cfg(c[5], c[4], c[3:1], c[0]);
                issue(2'd0, lo);
                check("R7", $sformatf("inside lo cfg=%0d", c), 32'(o_reject), 1);
                issue(2'd0, hi);
                check("R7", $sformatf("inside hi cfg=%0d", c), 32'(o_reject), 1);
                if (lo != 0) begin
                    issue(2'd0, lo - 1);
                    check("R7", $sformatf("below lo cfg=%0d", c), 32'(o_reject), 0);
                end
                if (hi != TOPA) begin
                    issue(2'd0, hi + 1);
                    check("R7", $sformatf("above hi cfg=%0d", c), 32'(o_reject), 0);
                end
            end
        end
    endtask

    task automatic test_op_kinds;
        set_cfg(1, 0, 3'd1, 0);               // top 4 kB: 1FF000..1FFFFF
        issue(2'd1, 21'h1FF123);
        check("R6", "sector inside", 32'(o_reject), 1);
        issue(2'd0, 21'h1FEFFF);
        check("R6", "page below", 32'(o_reject), 0);
        issue(2'd2, 21'h1F0000);
        check("R6", "block covering", 32'(o_reject), 1);
        issue(2'd1, 21'h1FE000);
        check("R6", "sector below", 32'(o_reject), 0);
        set_cfg(0, 1, 3'd1, 0);               // bottom 64 kB: 0..FFFF
        issue(2'd2, 21'h010000);
        check("R6", "block above", 32'(o_reject), 0);
        issue(2'd2, 21'h00FFFF);
        check("R6", "block inside", 32'(o_reject), 1);
        issue(2'd1, 21'h01F000);
        check("R6", "sector outside", 32'(o_reject), 0);
    endtask

    task automatic test_chip;
        set_cfg(0, 0, 3'd0, 0);
        issue(2'd3, 21'h0);
        check("R8", "chip no prot", 32'(o_reject), 0);
        set_cfg(1, 1, 3'd1, 0);
        issue(2'd3, 21'h123456 & TOPA);
        check("R8", "chip 4k prot", 32'(o_reject), 1);
        set_cfg(0, 0, 3'd6, 1);
        issue(2'd3, 21'h0);
        check("R8", "chip inverted full", 32'(o_reject), 0);
        set_cfg(0, 0, 3'd0, 1);
        issue(2'd3, 21'h0);
        check("R8", "chip inverted none", 32'(o_reject), 1);
    endtask

    task automatic test_timing;
        set_cfg(0, 0, 3'd1, 0);               // top 64 kB
        @(negedge clk);
        req_kind = 2'd0; req_addr = 21'h1F0000; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        check("R9", "done after strobe", 32'(o_done), 1);
        check("R9", "reject after strobe", 32'(o_reject), 1);
        set_cfg(0, 1, 3'd2, 0);
        @(negedge clk);
        check("R9", "done one cycle", 32'(o_done), 0);
        check("R9", "reject held", 32'(o_reject), 1);
        check("R9", "lo held", 32'(o_lo), 32'h1F0000);
        @(negedge clk);
        check("R9", "hi held", 32'(o_hi), 32'h1FFFFF);
        check("R9", "still idle", 32'(o_done), 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1;
        @(negedge clk);
        test_reset;
        test_all_combos;
        test_boundaries;
        test_op_kinds;
        test_chip;
        test_timing;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule